// File: doc/BRIEF.md
# MDIO Clause 22 Command Gateway Master

This block is a station-management master for clause 22 PHY access, driven through one command word. Software writes the word with its busy flag set. The word carries:

- the start bits and the opcode;
- the PHY and register addresses;
- for a write, the 16-bit data.

The block then generates MDC and serialises the frame on the MDIO pins: a 32-bit preamble, the header, the turnaround and the data. It clears busy when the frame ends.

For a read, the master releases the MDIO line for the turnaround and the data phase. It samples the PHY's bits at a programmable point inside each bit slot and places the 16-bit result in the data field of the same command word. A completed read leaves the gateway locked. Software must release it by writing zero before a new command is taken.

A second register selects three values, all counted in core-clock cycles:

- the MDC half-period;
- the phase at which the master drives a new bit;
- the phase at which it samples the input.

Each bit slot begins with the rising edge of MDC. The PHY samples each driven bit on the next rising edge.

The frame sequencer has six states:

- IDLE: waits for an accepted command word with busy set, then moves to PRE.
- PRE: sends 32 ones, then moves to HDR.
- HDR: sends the 14 header bits (start, opcode, PHY address, register address), then moves to TURN.
- TURN: spends two slots on the turnaround, then moves to DATA.
- DATA: spends 16 slots on the data, then moves to TAIL.
- TAIL: is one extra slot. It gives the PHY a final rising edge and releases the line, then returns to IDLE while clearing busy.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the gateway reads 0, MDC is low, mdio_oe is low, and the sample settings are: half-period value 9, input point 6, output point 13.
- R2: A gateway write with bit 30 (busy) set, made while idle and unlocked, starts a frame. Busy reads 1 from the next cycle and clears 65 slots after the start.
- R3: With half-period value P, every slot is 2*(P+1) cycles long. MDC is high for the first P+1 cycles of the slot and low for the remaining P+1 cycles, and MDC stays low whenever no frame is active.
- R4: The frame is sent MSB first, one bit per slot, in this order: 32 ones, then gateway bits [29:28] (start), [27:26] (opcode), [25:21] (PHY address) and [20:16] (register address). Each bit is valid at the following MDC rising edge.
- R5: For any opcode other than 2'b10, the turnaround is driven as 1 then 0 and followed by gateway bits [15:0], with mdio_oe high for all 64 bits.
- R6: For opcode 2'b10 (read), mdio_oe is low in the turnaround and data slots. mdio_i is sampled at the input point of each data slot, MSB first, and the 16 bits appear in gateway bits [15:0] when busy clears.
- R7: In each slot, mdio_o and mdio_oe take their new value in the cycle after the slot phase equals the output point.
- R8: A completed read locks the gateway. While it is locked, non-zero gateway writes are ignored. Writing zero clears the gateway and unlocks it.
- R9: A gateway write while busy is set is ignored: the frame on the wire and the stored word are unchanged.
- R10: Writes to the configuration register (address 1) set the half-period [7:0], the input point [15:8] and the output point [23:16]. The new values are used by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the gateway, 1 selects the configuration |
| reg_wdata | input | 32 | Write data |
| gw_rdata | output | 32 | Current gateway word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Several properties are checked on every cycle:

- MDC stays low while busy is clear.
- The slot phase never passes the end of its slot.
- mdio_oe stays low during the data phase of a read.
- The gateway is never both locked and busy.
- An accepted command raises busy.
- A write made during a frame leaves the stored word untouched.

Some behaviours can only be shown by the bench scenarios, against its cycle-by-cycle model:

- the exact bit order and turnaround pattern seen on the MDC rising edges;
- the cycle in which the output point takes effect;
- the capture of read data at the input point while the PHY changes the line just after it;
- lock release;
- the effect of reprogramming the slot timing.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;
    localparam int CFG_W   = 8;
    localparam int DAT_W   = 16;
    localparam int ADR_W   = 5;
    localparam int PRE_LEN = 32;
    localparam int HDR_LEN = 4 + 2 * ADR_W;
    localparam int FRM_LEN = PRE_LEN + HDR_LEN + 2 + DAT_W;
    localparam int SLOT_W  = $clog2(FRM_LEN + 1);
    localparam int BUSY_B  = 30;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_HDR, ST_TURN, ST_DATA, ST_TAIL
    } mdio_st_e;

    typedef struct packed {
        logic [CFG_W-1:0] outpt;
        logic [CFG_W-1:0] inpt;
        logic [CFG_W-1:0] half;
    } mdio_cfg_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    input  logic [CW-1:0] inpt,
    input  logic [CW-1:0] outpt,
    output logic          mdc,
    output logic          drive_stb,
    output logic          samp_stb,
    output logic          slot_end
);
    logic [CW:0] phase;
    logic [CW:0] last;

    assign last = {half, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      phase <= '0;
        else if (!run || phase == last)  phase <= '0;
        else                             phase <= phase + 1'b1;
    end

    assign mdc       = run && (phase <= {1'b0, half});
    assign drive_stb = run && (phase == {1'b0, outpt});
    assign samp_stb  = run && (phase == {1'b0, inpt});
    assign slot_end  = run && (phase == last);

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> phase <= last);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_gw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRM_LEN-1:0] frame_in,
    input  logic               is_rd,
    input  logic               drive_stb,
    input  logic               samp_stb,
    input  logic               slot_end,
    input  logic               mdio_i,
    output logic               run,
    output logic               done,
    output logic               rd_flag,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DAT_W-1:0]   rd_data
);
    localparam logic [SLOT_W-1:0] PRE_END  = SLOT_W'(PRE_LEN - 1);
    localparam logic [SLOT_W-1:0] HDR_END  = SLOT_W'(PRE_LEN + HDR_LEN - 1);
    localparam logic [SLOT_W-1:0] TURN_END = SLOT_W'(PRE_LEN + HDR_LEN + 1);
    localparam logic [SLOT_W-1:0] DATA_END = SLOT_W'(FRM_LEN - 1);

    mdio_st_e            state, state_nx;
    logic [SLOT_W-1:0]   slot;
    logic [FRM_LEN-1:0]  shreg;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)                          state_nx = ST_PRE;
            ST_PRE:  if (slot_end && slot == PRE_END)    state_nx = ST_HDR;
            ST_HDR:  if (slot_end && slot == HDR_END)    state_nx = ST_TURN;
            ST_TURN: if (slot_end && slot == TURN_END)   state_nx = ST_DATA;
            ST_DATA: if (slot_end && slot == DATA_END)   state_nx = ST_TAIL;
            ST_TAIL: if (slot_end)                       state_nx = ST_IDLE;
            default:                                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot    <= '0;
            shreg   <= '0;
            rd_flag <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                slot    <= '0;
                shreg   <= frame_in;
                rd_flag <= is_rd;
            end else if (slot_end) begin
                slot <= slot + 1'b1;
            end
            if (drive_stb) begin
                if (state == ST_TAIL) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    mdio_o  <= shreg[FRM_LEN-1];
                    shreg   <= {shreg[FRM_LEN-2:0], 1'b0};
                    mdio_oe <= !(rd_flag && (state == ST_TURN || state == ST_DATA));
                end
            end
            if (samp_stb && state == ST_DATA)
                rd_data <= {rd_data[DAT_W-2:0], mdio_i};
        end
    end

    assign run  = (state != ST_IDLE);
    assign done = (state == ST_TAIL) && slot_end;

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && rd_flag) |-> !mdio_oe);
    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> slot <= SLOT_W'(FRM_LEN));
endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
    import mdio_gw_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_HALF = 8'd9,
    parameter logic [CFG_W-1:0] DEF_IN   = 8'd6,
    parameter logic [CFG_W-1:0] DEF_OUT  = 8'd13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] gw_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [31:0]        gw_q;
    logic               locked;
    mdio_cfg_t          cfg_q;
    logic               busy, accept, start, is_rd;
    logic               run, done, rd_flag;
    logic               drive_stb, samp_stb, slot_end;
    logic [DAT_W-1:0]   rd_data;
    logic [FRM_LEN-1:0] frame_in;

    assign busy   = gw_q[BUSY_B];
    assign accept = reg_wr && !reg_addr && !busy && (!locked || reg_wdata == '0);
    assign start  = accept && reg_wdata[BUSY_B];
    assign is_rd  = (reg_wdata[27:26] == 2'b10);
    assign frame_in = {{PRE_LEN{1'b1}}, reg_wdata[29:16],
                       (is_rd ? 2'b00 : 2'b10), reg_wdata[DAT_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gw_q   <= '0;
            locked <= 1'b0;
            cfg_q  <= '{outpt: DEF_OUT, inpt: DEF_IN, half: DEF_HALF};
        end else begin
            if (accept) begin
                gw_q   <= reg_wdata;
                locked <= 1'b0;
            end else if (done) begin
                gw_q[BUSY_B] <= 1'b0;
                if (rd_flag) begin
                    gw_q[DAT_W-1:0] <= rd_data;
                    locked          <= 1'b1;
                end
            end
            if (reg_wr && reg_addr && !busy)
                cfg_q <= reg_wdata[3*CFG_W-1:0];
        end
    end

    assign gw_rdata = gw_q;

    mdio_clk_gen #(.CW(CFG_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .half(cfg_q.half), .inpt(cfg_q.inpt), .outpt(cfg_q.outpt),
        .mdc(mdc), .drive_stb(drive_stb), .samp_stb(samp_stb), .slot_end(slot_end)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame_in),
        .is_rd(is_rd), .drive_stb(drive_stb), .samp_stb(samp_stb),
        .slot_end(slot_end), .mdio_i(mdio_i), .run(run), .done(done),
        .rd_flag(rd_flag), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
    );

    // R3
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8
    lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !busy);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !busy && !locked && reg_wdata[BUSY_B]) |=> busy);
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && reg_wr && !reg_addr) |=> $stable(gw_q));
endmodule

// File: tb/test_mdio_gw_master.sv
module test_mdio_gw_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] gw_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic smp_o [64];
    logic smp_oe[64];

    always #10 clk = ~clk;

    mdio_gw_master i_mdio_gw_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .gw_rdata(gw_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Runs one frame against a behavioural model of MDC and of the PHY side.
    task automatic run_frame(input logic [31:0] cmd, input logic [15:0] resp,
                             input int p, input int inp, input int outp,
                             input bit inject);
        int tslot = 2 * (p + 1);
        int total = 65 * tslot;
        bit rd = (cmd[27:26] == 2'b10);
        logic [63:0] exp_bits = {32'hFFFF_FFFF, cmd[29:16],
                                 (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : cmd[15:0])};
        logic [31:0] exp_gw;
        int  rises = 0;
        bit  prev = 0;
        bit  mdc_ok = 1;
        int  bad_k = -1;
        bit  phy_bit = 1;
        bit  bits_ok = 1, oe_ok = 1;
        int  bad_i = -1;
        reg_write(1'b0, cmd);
        for (int k = 0; k <= total; k++) begin
            bit em = (k < total) && ((k % tslot) <= p);
            if (mdc !== em && mdc_ok) begin mdc_ok = 0; bad_k = k; end
            if (k == 0)
                chk(gw_rdata[30] === 1'b1, "R2", "busy after accept", {31'b0, gw_rdata[30]}, 32'h1);
            if (k == outp)
                chk(mdio_oe === 1'b0, "R7", "oe before output point", {31'b0, mdio_oe}, 32'h0);
            if (k == outp + 1)
                chk(mdio_oe === 1'b1, "R7", "oe after output point", {31'b0, mdio_oe}, 32'h1);
            if (mdc && !prev) begin
                rises++;
                if (rises >= 2) begin
                    smp_o [rises-2] = mdio_o;
                    smp_oe[rises-2] = mdio_oe;
                end
                if (rd && (rises - 1) >= 48 && (rises - 1) <= 63) begin
                    phy_bit = resp[15 - (rises - 1 - 48)];
                    mdio_i  = phy_bit;
                end
            end
            // PHY line turns to the wrong value right after the input point (R6)
            if (rd && rises >= 49 && rises <= 64 && (k % tslot) == inp + 1)
                mdio_i = ~phy_bit;
            if (inject && k == 30 * tslot + 3) begin
                reg_addr = 1'b0; reg_wdata = 32'h4FFF_1234; reg_wr = 1'b1;
            end
            if (inject && k == 30 * tslot + 4) reg_wr = 1'b0;
            prev = mdc;
            if (k < total) @(negedge clk);
        end
        mdio_i = 1'b1;
        chk(mdc_ok, "R3", "MDC waveform vs model", bad_k, 32'hFFFF_FFFF);
        chk(rises == 65, "R3", "rising edge count", rises, 65);
        for (int i = 0; i < 64; i++) begin
            bit eoe = !(rd && i >= 46);
            if (smp_oe[i] !== eoe && oe_ok) begin oe_ok = 0; bad_i = i; end
            if (eoe && smp_o[i] !== exp_bits[63-i] && bits_ok) begin bits_ok = 0; bad_i = i; end
        end
        chk(bits_ok, rd ? "R4" : "R5", "frame bits at MDC rise", bad_i, 32'hFFFF_FFFF);
        chk(oe_ok, rd ? "R6" : "R5", "output enable per slot", bad_i, 32'hFFFF_FFFF);
        exp_gw = cmd & ~32'h4000_0000;
        if (rd) exp_gw[15:0] = resp;
        chk(gw_rdata === exp_gw, rd ? "R6" : (inject ? "R9" : "R2"),
            "gateway after frame", gw_rdata, exp_gw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(gw_rdata === 32'h0, "R1", "gateway after reset", gw_rdata, 32'h0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "mdc/oe after reset",
            {30'b0, mdc, mdio_oe}, 32'h0);
        // R1/R4/R5 write frame with reset timing: start 01, op 01
        run_frame({2'b01, 2'b01, 2'b01, 5'h15, 5'h0A, 16'hA5C3}, 16'h0, 9, 6, 13, 0);
        // R9 write while busy ignored
        run_frame({2'b01, 2'b01, 2'b01, 5'h03, 5'h1F, 16'h0F0F}, 16'h0, 9, 6, 13, 1);
        // R6 read frame
        run_frame({2'b01, 2'b01, 2'b10, 5'h1B, 5'h04, 16'h0000}, 16'hC35A, 9, 6, 13, 0);
        // R8 locked: new command ignored
        reg_write(1'b0, 32'h5421_BEEF);
        repeat (3) @(negedge clk);
        chk(gw_rdata === {16'h1B64 & 16'hBFFF, 16'hC35A} || gw_rdata === 32'h1B64C35A,
            "R8", "locked gateway unchanged", gw_rdata, 32'h1B64C35A);
        chk(mdc === 1'b0, "R8", "no frame while locked", {31'b0, mdc}, 32'h0);
        reg_write(1'b0, 32'h0);
        chk(gw_rdata === 32'h0, "R8", "zero write releases", gw_rdata, 32'h0);
        // R10 new timing: half 7, in 3, out 12
        reg_write(1'b1, {8'd12, 8'd3, 8'd7});
        run_frame({2'b01, 2'b01, 2'b10, 5'h01, 5'h11, 16'h0000}, 16'h3C96, 7, 3, 12, 0);
        reg_write(1'b0, 32'h0);
        run_frame({2'b01, 2'b01, 2'b01, 5'h1F, 5'h00, 16'hFFFE}, 16'h0, 7, 3, 12, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule